// File: doc/BRIEF.md
# Two-Axis Offset and Gain Trimmer

This block trims the raw outputs of a two-axis acceleration path. Once per output sample, a decimation stage hands over one 31-bit word per axis and raises a single-cycle start strobe. For each axis, the block first shortens the word to 24 bits. It then adds a signed per-axis offset and scales the sum by an unsigned per-axis gain. The two corrected 24-bit words are presented together with a one-cycle completion pulse.

Area is saved by using one iterative radix-4 Booth multiplier for both axes. The X axis is processed first and the Y axis second. All of this happens inside one sample period, which is long compared with the 22 clock cycles the sequence needs. The offset and gain values come from static register inputs and are captured when the sequence starts. If a start strobe arrives while a sequence is running, it is dropped and a sticky overrun flag is raised. The flag stays set until the overrun clear input is pulsed.

Top module: `axis_trim_corrector`

## Requirements
- R1: After reset, x_out and y_out are zero, and done and overrun are low.
- R2: Each 31-bit input is cut to its upper 24 bits (bits 30 down to 7), read as two's complement. The seven lower bits are dropped without rounding, so the value is floored.
- R3: The signed 24-bit offset is added to the cut word. The sum is clamped to the range -8388608 to 8388607.
- R4: The gain is an unsigned 16-bit value with 15 fraction bits, so 0x8000 means unity. The offset-corrected value is multiplied by the gain and shifted right arithmetically by 15, which floors the result toward minus infinity. The result is clamped to the signed 24-bit range.
- R5: done is a one-cycle pulse. It is high in the 22nd clock cycle after the edge that accepts sample_valid. At that point both outputs hold the new results.
- R6: The inputs, offsets and gains are captured on the accepting edge. Changing any of them later has no effect on that sequence's results.
- R7: A sample_valid that arrives while a sequence runs is ignored: it produces no extra done pulse and does not change the results. It sets overrun, and overrun stays high until overrun_clr is asserted. When a set and a clear happen in the same cycle, the set wins.
- R8: Between sequences, x_out and y_out hold their values whatever the inputs do.
- R9: The X axis is finished first: x_out takes its new value 11 cycles after the accepting edge, and y_out takes its new value 11 cycles after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied on the clock edge |
| sample_valid | input | 1 | One-cycle strobe that marks a new pair of words |
| overrun_clr | input | 1 | Clears the overrun flag |
| x_in | input | 31 | X-axis word from the decimation stage |
| y_in | input | 31 | Y-axis word from the decimation stage |
| x_offset | input | 24 | Signed X-axis offset |
| y_offset | input | 24 | Signed Y-axis offset |
| x_gain | input | 16 | Unsigned X-axis gain, 15 fraction bits |
| y_gain | input | 16 | Unsigned Y-axis gain, 15 fraction bits |
| x_out | output | 24 | Corrected X-axis word |
| y_out | output | 24 | Corrected Y-axis word |
| done | output | 1 | One-cycle pulse when both results are ready |
| overrun | output | 1 | Sticky flag for a dropped start strobe |

## Verification
A wrong Booth digit count or a wrong partial-product decode shows up as a wrong product on the very next done pulse. The gain values used in the checks are chosen so that every digit kind occurs: zero, plus or minus one, and plus or minus two. An error in the step sequence or in axis selection moves the times at which x_out and y_out change away from cycles 11 and 22, or swaps the two axes' coefficients, so it becomes visible within a single sample. A flaw in capture or in the busy guard corrupts the results of the sequence that was disturbed, or causes a second done pulse within 22 cycles.

// File: rtl/axis_trim_corrector.sv
module axis_trim_corrector #(
  parameter int IN_W   = 31,
  parameter int OUT_W  = 24,
  parameter int GAIN_W = 16,
  parameter int FRAC   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic              overrun_clr,
  input  logic [IN_W-1:0]   x_in,
  input  logic [IN_W-1:0]   y_in,
  input  logic [OUT_W-1:0]  x_offset,
  input  logic [OUT_W-1:0]  y_offset,
  input  logic [GAIN_W-1:0] x_gain,
  input  logic [GAIN_W-1:0] y_gain,
  output logic [OUT_W-1:0]  x_out,
  output logic [OUT_W-1:0]  y_out,
  output logic              done,
  output logic              overrun
);
  localparam int DIGITS = (GAIN_W + 2) / 2;
  localparam int PROD_W = OUT_W + GAIN_W + 2;
  localparam int MR_W   = GAIN_W + 2;
  localparam int CNT_W  = $clog2(DIGITS + 1);
  localparam logic [OUT_W-1:0] SAT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] SAT_MIN = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic signed [PROD_W-1:0] P_MAX = {{(PROD_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] P_MIN = {{(PROD_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_MUL, S_STORE} seq_t;

  seq_t                      state;
  logic                      ax;
  logic [OUT_W-1:0]          tx, ty, ox, oy;
  logic [GAIN_W-1:0]         gx, gy;
  logic signed [PROD_W-1:0]  mcand, acc, pp, scaled;
  logic [MR_W-1:0]           mr;
  logic [CNT_W-1:0]          cnt;

  wire busy = (state != S_IDLE);

  wire [OUT_W-1:0]  cur_t = ax ? ty : tx;
  wire [OUT_W-1:0]  cur_o = ax ? oy : ox;
  wire [GAIN_W-1:0] cur_g = ax ? gy : gx;

  wire [OUT_W:0] sum = {cur_t[OUT_W-1], cur_t} + {cur_o[OUT_W-1], cur_o};
  wire [OUT_W-1:0] sum_sat = (sum[OUT_W] != sum[OUT_W-1]) ?
                             (sum[OUT_W] ? SAT_MIN : SAT_MAX) : sum[OUT_W-1:0];

  always_comb begin
    case (mr[2:0])
      3'b001, 3'b010: pp = mcand;
      3'b011:         pp = mcand <<< 1;
      3'b100:         pp = -(mcand <<< 1);
      3'b101, 3'b110: pp = -mcand;
      default:        pp = '0;
    endcase
  end

  assign scaled = acc >>> FRAC;
  wire [OUT_W-1:0] res_sat = (scaled > P_MAX) ? SAT_MAX :
                             (scaled < P_MIN) ? SAT_MIN : scaled[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ax      <= 1'b0;
      tx      <= '0;
      ty      <= '0;
      ox      <= '0;
      oy      <= '0;
      gx      <= '0;
      gy      <= '0;
      mcand   <= '0;
      acc     <= '0;
      mr      <= '0;
      cnt     <= '0;
      x_out   <= '0;
      y_out   <= '0;
      done    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      done <= 1'b0;
      if (overrun_clr) overrun <= 1'b0;
      if (sample_valid && busy) overrun <= 1'b1;
      case (state)
        S_IDLE: if (sample_valid) begin
          tx    <= x_in[IN_W-1:IN_W-OUT_W];
          ty    <= y_in[IN_W-1:IN_W-OUT_W];
          ox    <= x_offset;
          oy    <= y_offset;
          gx    <= x_gain;
          gy    <= y_gain;
          ax    <= 1'b0;
          state <= S_PREP;
        end
        S_PREP: begin
          mcand <= {{(PROD_W-OUT_W){sum_sat[OUT_W-1]}}, sum_sat};
          mr    <= {1'b0, cur_g, 1'b0};
          acc   <= '0;
          cnt   <= '0;
          state <= S_MUL;
        end
        S_MUL: begin
          acc   <= acc + pp;
          mcand <= mcand <<< 2;
          mr    <= mr >> 2;
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_W'(DIGITS - 1)) state <= S_STORE;
        end
        S_STORE: begin
          if (!ax) begin
            x_out <= res_sat;
            ax    <= 1'b1;
            state <= S_PREP;
          end else begin
            y_out <= res_sat;
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module axis_trim_corrector_chk #(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_valid,
  input logic             overrun_clr,
  input logic             busy,
  input logic             done,
  input logic             overrun,
  input logic [OUT_W-1:0] x_out,
  input logic [OUT_W-1:0] y_out
);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_start_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sample_valid));
  p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sample_valid) |=> overrun);
  p_overrun_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !overrun_clr) |=> overrun);
  p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(busy && sample_valid));
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(x_out) && $stable(y_out)));
endmodule

bind axis_trim_corrector axis_trim_corrector_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
  .overrun_clr(overrun_clr), .busy(busy), .done(done), .overrun(overrun),
  .x_out(x_out), .y_out(y_out)
);

// File: tb/test_axis_trim_corrector.sv
module test_axis_trim_corrector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic        overrun_clr = 1'b0;
  logic [30:0] x_in = '0, y_in = '0;
  logic [23:0] x_offset = '0, y_offset = '0, x_out, y_out;
  logic [15:0] x_gain = '0, y_gain = '0;
  logic        done, overrun;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  axis_trim_corrector i_axis_trim_corrector (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .overrun_clr(overrun_clr), .x_in(x_in), .y_in(y_in),
    .x_offset(x_offset), .y_offset(y_offset), .x_gain(x_gain), .y_gain(y_gain),
    .x_out(x_out), .y_out(y_out), .done(done), .overrun(overrun)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clamp24(input longint v);
    if (v > 8388607) return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  function automatic longint model(input logic [30:0] win, input logic [23:0] off,
                                   input logic [15:0] g);
    longint t, s, p;
    t = $signed(win[30:7]);
    s = clamp24(t + longint'($signed(off)));
    p = s * longint'(g);
    return clamp24(p >>> 15);
  endfunction

  // mode 0: clean; 1: disturb inputs mid-run; 2: also extra strobe; 3: strobe with clear
  task automatic run(input string req, input logic [30:0] xi, input logic [30:0] yi,
                     input logic [23:0] xo, input logic [23:0] yo,
                     input logic [15:0] xg, input logic [15:0] yg,
                     input int mode, output int lat, output int xat);
    logic [23:0] px;
    @(negedge clk);
    x_in = xi; y_in = yi; x_offset = xo; y_offset = yo; x_gain = xg; y_gain = yg;
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    lat = 0; xat = -1; px = x_out;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
      if (xat < 0 && x_out !== px) xat = lat;
      sample_valid = 1'b0; overrun_clr = 1'b0;
      if (lat == 3 && mode >= 1) begin
        x_in = ~xi; y_in = ~yi; x_offset = ~xo; y_offset = ~yo;
        x_gain = ~xg; y_gain = ~yg;
        if (mode >= 2) sample_valid = 1'b1;
        if (mode == 3) overrun_clr = 1'b1;
      end
    end
    check({req, " x_out"}, $signed(x_out), model(xi, xo, xg));
    check({req, " y_out"}, $signed(y_out), model(yi, yo, yg));
  endtask

  task automatic t_reset;
    check("R1 x_out reset", x_out, 0);
    check("R1 y_out reset", y_out, 0);
    check("R1 done reset", done, 0);
    check("R1 overrun reset", overrun, 0);
  endtask

  task automatic t_truncate;
    int l, xa;
    run("R2 floor", {24'd5, 7'h7F}, {24'hFFFFFE, 7'h7F}, 24'd0, 24'd0,
        16'h8000, 16'h8000, 0, l, xa);
    check("R2 x explicit", $signed(x_out), 5);
    check("R2 y explicit", $signed(y_out), -2);
  endtask

  task automatic t_offset;
    int l, xa;
    run("R3 sat", {24'h7FFFF0, 7'h11}, {24'h800010, 7'h00}, 24'h000100, 24'hFFFF00,
        16'h8000, 16'h8000, 0, l, xa);
    check("R3 high clamp", $signed(x_out), 8388607);
    check("R3 low clamp", $signed(y_out), -8388608);
    run("R3 plain", {24'd1000, 7'h0}, {24'hFFFC18, 7'h0}, 24'd234, 24'hFFFFF6,
        16'h8000, 16'h8000, 0, l, xa);
  endtask

  task automatic t_gain;
    int l, xa;
    run("R4 big gain sat", {24'h600000, 7'h0}, {24'hA00000, 7'h0}, 24'd0, 24'd0,
        16'hFFFF, 16'hFFFF, 0, l, xa);
    check("R4 pos clamp", $signed(x_out), 8388607);
    check("R4 neg clamp", $signed(y_out), -8388608);
    run("R4 floor half", {24'hFFFFFD, 7'h0}, {24'd1000, 7'h0}, 24'd0, 24'd0,
        16'h4000, 16'hC000, 0, l, xa);
    check("R4 -1.5 floors", $signed(x_out), -2);
    check("R4 1.5x", $signed(y_out), 1500);
    run("R4 zero gain", {24'h123456, 7'h3}, {24'hABCDEF, 7'h5}, 24'd77, 24'hFFF000,
        16'h0000, 16'h5A5B, 0, l, xa);
    run("R4 mixed", {24'h3C3C3C, 7'h0}, {24'hC0FFEE, 7'h0}, 24'hFFFF12, 24'h0000AB,
        16'h9D71, 16'h2B6A, 0, l, xa);
  endtask

  task automatic t_timing;
    int l, xa;
    run("R5 seq", {24'd300, 7'h0}, {24'd400, 7'h0}, 24'd0, 24'd0,
        16'h8000, 16'h8000, 0, l, xa);
    run("R9 seq", {24'd111, 7'h0}, {24'd222, 7'h0}, 24'd0, 24'd0,
        16'h8000, 16'h8000, 0, l, xa);
    check("R5 latency", l, 22);
    check("R9 x update cycle", xa, 11);
    @(negedge clk);
    check("R5 single pulse", done, 0);
  endtask

  task automatic t_capture;
    int l, xa;
    run("R6 capture", {24'h012345, 7'h40}, {24'hFEDCBA, 7'h01}, 24'h000321, 24'hFFF123,
        16'hA3C5, 16'h6E19, 1, l, xa);
    check("R6 latency undisturbed", l, 22);
  endtask

  task automatic t_overrun;
    int l, xa, extra;
    run("R7 ignored strobe", {24'd5000, 7'h0}, {24'hFFEC78, 7'h0}, 24'd10, 24'd20,
        16'h8000, 16'hC000, 2, l, xa);
    check("R7 latency kept", l, 22);
    check("R7 overrun set", overrun, 1);
    extra = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R7 no extra done", extra, 0);
    check("R7 overrun sticky", overrun, 1);
    overrun_clr = 1'b1;
    @(negedge clk);
    overrun_clr = 1'b0;
    check("R7 overrun cleared", overrun, 0);
    run("R7 set beats clear", {24'd7, 7'h0}, {24'd9, 7'h0}, 24'd0, 24'd0,
        16'h8000, 16'h8000, 3, l, xa);
    check("R7 set wins", overrun, 1);
    overrun_clr = 1'b1;
    @(negedge clk);
    overrun_clr = 1'b0;
  endtask

  task automatic t_hold;
    logic [23:0] hx, hy;
    int d;
    hx = x_out; hy = y_out; d = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      x_in = 31'(i * 977); y_in = ~x_in; x_offset = 24'(i); y_offset = 24'(i * 3);
      x_gain = 16'(i * 4099); y_gain = ~x_gain;
      if (done) d++;
    end
    check("R8 x held", x_out, hx);
    check("R8 y held", y_out, hy);
    check("R8 no done", d, 0);
  endtask

  initial begin
    #2_000_000;
    nchk++; nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_truncate();
    t_offset();
    t_gain();
    t_timing();
    t_capture();
    t_overrun();
    t_hold();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule